// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupting devices and a processor. Each maskable device owns one request line with a fixed priority: line `irq_req[i]` carries level i+1. A separate non-maskable request carries the top level, N_SRC+1. Level 0 means the processor is running foreground code. Requests are synchronized and arbitrated. The block accepts the highest-level eligible request only when the processor reports that it can take an interrupt, and only when that level is strictly above the level now in service.

On acceptance the block raises an acknowledge to the winning device and waits for that device to place a vector on a shared vector bus, marked by `vec_valid`. A captured vector is handed to the processor as a one-cycle `int_valid` pulse on `int_vector`, and the processor uses it as the handler index. If no vector arrives within `TMO_LIMIT` cycles, a one-cycle `int_buserr` pulse is issued instead. The service level is then rolled back.

The running level is held inside the block as `cur_level`. Each acceptance saves the level it interrupted on a small stack. An end-of-service pulse from the processor returns to the most recently saved level. This lets a higher interrupt preempt a lower one, and a masked request is taken as soon as the level falls below it.

Top module: `pvic_top`

## Requirements
- R1: After reset, all acknowledge outputs, `int_valid` and `int_buserr` are 0, and `cur_level` is 0.
- R2: Among simultaneous eligible requests, only the one with the highest level is acknowledged, and the acknowledge outputs are one-hot or zero. `irq_req[i]` has level i+1 and acknowledge `dev_ack[i]`. The non-maskable request has level N_SRC+1 and acknowledge `nmi_ack`.
- R3: A maskable request whose level is not strictly above `cur_level` is never acknowledged. While the device holds it, it is acknowledged one cycle after `cur_level` drops below its level.
- R4: A rising edge on `nmi_req` is remembered until it is accepted. It is accepted at any `cur_level` below N_SRC+1. While non-maskable service is running, the remembered edge waits for that service to end. Holding `nmi_req` high causes no further acceptance.
- R5: Acceptance requires `cpu_ready` high and no `cpu_eos` in that cycle. With the block idle and ready, the acknowledge rises 3 cycles after a maskable request rises and 4 cycles after `nmi_req` rises.
- R6: The acknowledge stays high until `vec_valid` is sampled high or `TMO_LIMIT` cycles have passed, and it is low in the next cycle.
- R7: When `vec_valid` is sampled high during the acknowledge, the next cycle shows `int_valid` = 1 and `int_vector` equal to the `vec_data` sampled. `int_valid` lasts exactly one cycle.
- R8: When no vector arrives within `TMO_LIMIT` cycles, `int_buserr` pulses for one cycle, `int_valid` stays 0, and `cur_level` returns to its value before the acceptance.
- R9: When the acknowledge rises, `cur_level` equals the accepted level. A `cpu_eos` pulse while no handshake is running restores the most recently saved level. With nothing saved, `cpu_eos` leaves `cur_level` at 0. During a handshake, `cpu_eos` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_SRC | Maskable request lines, bit i at level i+1 |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| cpu_ready | input | 1 | Processor can take an interrupt |
| cpu_eos | input | 1 | End-of-service pulse from the processor |
| vec_valid | input | 1 | Acknowledged device drives a vector |
| vec_data | input | VEC_W | Vector bus from the devices |
| dev_ack | output | N_SRC | Acknowledge to maskable devices |
| nmi_ack | output | 1 | Acknowledge to the non-maskable source |
| int_valid | output | 1 | One-cycle pulse: vector ready for the processor |
| int_vector | output | VEC_W | Captured handler index |
| int_buserr | output | 1 | One-cycle pulse: vector timeout |
| cur_level | output | LVL_W | Level now in service, 0 for foreground |

## Verification
A maskable acknowledge is due three clock edges after its request changes: two synchronizer stages plus the decision. A non-maskable acknowledge needs one more edge for the edge detector. After an end-of-service pulse or a raise of `cpu_ready`, a held request is acknowledged on the very next edge. The bench drives and samples one nanosecond after each rising edge. It counts edges from the stimulus and checks the acknowledge, `cur_level` and the absence of a grant in exactly those cycles. Vectors are presented after every delay from 1 to `TMO_LIMIT` cycles, with `int_valid` checked one edge after the sampled strobe. In the no-vector case, the acknowledge is checked still high at edge `TMO_LIMIT`-1 and `int_buserr` with the restored level at edge `TMO_LIMIT`.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } hs_state_t;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= 2'b00;
      else     sh <= {sh[0], d[g]};
    end
    assign q[g] = sh[1];
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int N_IN  = 5,
  parameter int LVL_W = 3
) (
  input  logic [N_IN-1:0]  req,
  input  logic [LVL_W-1:0] cur_lvl,
  output logic             win_valid,
  output logic [N_IN-1:0]  win_onehot,
  output logic [LVL_W-1:0] win_lvl
);
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [N_IN-1:0]  elig;
  logic [IDX_W-1:0] win_idx;

  // line i sits at level i+1; only strictly higher levels are eligible
  for (genvar g = 0; g < N_IN; g++) begin : g_elig
    assign elig[g] = req[g] && (LVL_W'(g + 1) > cur_lvl);
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (elig[i]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end

  assign win_onehot = win_valid ? (N_IN'(1) << win_idx) : '0;
  assign win_lvl    = LVL_W'(win_idx) + LVL_W'(1);
endmodule

// File: rtl/pvic_lvl_stack.sv
module pvic_lvl_stack #(
  parameter int DEPTH = 5,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int SP_W   = $clog2(DEPTH + 1);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_m1;

  assign sp_m1 = sp - SP_W'(1);
  assign empty = (sp == '0);
  assign full  = (sp == SP_W'(DEPTH));

  // storage without reset so it can map onto memory
  always_ff @(posedge clk) begin
    if (push) mem[sp[ADDR_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + SP_W'(1);
    else if (pop)  sp <= sp_m1;
  end

  assign top = empty ? '0 : mem[sp_m1[ADDR_W-1:0]];

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R9
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst) !(push && pop)); // R9
endmodule

// File: rtl/pvic_ack_fsm.sv
module pvic_ack_fsm
  import pvic_pkg::*;
#(
  parameter int N_IN      = 5,
  parameter int VEC_W     = 4,
  parameter int TMO_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_IN-1:0]  start_oh,
  input  logic             vec_valid,
  input  logic [VEC_W-1:0] vec_data,
  output logic [N_IN-1:0]  ack_vec,
  output logic             busy,
  output logic             tmo_fire,
  output logic             int_valid,
  output logic [VEC_W-1:0] int_vector,
  output logic             int_buserr
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_LIMIT - 1);

  hs_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic             cap_fire;

  assign busy     = (st == ST_ACK);
  assign cap_fire = busy && vec_valid;
  assign tmo_fire = busy && !vec_valid && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      ack_vec    <= '0;
      int_valid  <= 1'b0;
      int_buserr <= 1'b0;
      int_vector <= '0;
    end else begin
      int_valid  <= cap_fire;
      int_buserr <= tmo_fire;
      if (cap_fire) int_vector <= vec_data;
      if (st == ST_IDLE) begin
        if (start) begin
          st      <= ST_ACK;
          ack_vec <= start_oh;
          cnt     <= '0;
        end
      end else begin
        if (cap_fire || tmo_fire) begin
          st      <= ST_IDLE;
          ack_vec <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ack_vec)); // R2
  AST_ACK_END_REASON: assert property (@(posedge clk) disable iff (rst) $fell(|ack_vec) |-> (int_valid || int_buserr)); // R6
  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) int_valid |-> $past(|ack_vec)); // R7
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (rst) !(int_valid && int_buserr)); // R8
  AST_RESULT_ACK_LOW: assert property (@(posedge clk) disable iff (rst) (int_valid || int_buserr) |-> (ack_vec == '0)); // R6
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
  parameter int N_SRC     = 4,
  parameter int VEC_W     = 4,
  parameter int TMO_LIMIT = 8,
  localparam int LVL_W    = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             nmi_req,
  input  logic             cpu_ready,
  input  logic             cpu_eos,
  input  logic             vec_valid,
  input  logic [VEC_W-1:0] vec_data,
  output logic [N_SRC-1:0] dev_ack,
  output logic             nmi_ack,
  output logic             int_valid,
  output logic [VEC_W-1:0] int_vector,
  output logic             int_buserr,
  output logic [LVL_W-1:0] cur_level
);
  localparam int N_IN      = N_SRC + 1;
  localparam int STK_DEPTH = N_SRC + 1;

  logic [N_IN-1:0]  req_s;
  logic             nmi_d;
  logic             nmi_pend;
  logic             nmi_edge;
  logic [N_IN-1:0]  arb_req;
  logic             win_valid;
  logic [N_IN-1:0]  win_onehot;
  logic [LVL_W-1:0] win_lvl;
  logic             busy;
  logic             tmo_fire;
  logic             accept;
  logic             eos_pop;
  logic             stk_pop;
  logic [LVL_W-1:0] stk_top;
  logic             stk_empty;
  logic             stk_full;
  logic [N_IN-1:0]  ack_vec;

  pvic_sync #(.W(N_IN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({nmi_req, irq_req}),
    .q   (req_s)
  );

  assign nmi_edge = req_s[N_SRC] && !nmi_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_d    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_d <= req_s[N_SRC];
      if (nmi_edge)                          nmi_pend <= 1'b1;
      else if (accept && win_onehot[N_SRC])  nmi_pend <= 1'b0;
    end
  end

  assign arb_req = {nmi_pend, req_s[N_SRC-1:0]};

  pvic_arbiter #(.N_IN(N_IN), .LVL_W(LVL_W)) u_arb (
    .req        (arb_req),
    .cur_lvl    (cur_level),
    .win_valid  (win_valid),
    .win_onehot (win_onehot),
    .win_lvl    (win_lvl)
  );

  assign accept  = win_valid && !busy && cpu_ready && !cpu_eos;
  assign eos_pop = cpu_eos && !busy && !stk_empty;
  assign stk_pop = eos_pop || tmo_fire;

  pvic_lvl_stack #(.DEPTH(STK_DEPTH), .W(LVL_W)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .pop   (stk_pop),
    .din   (cur_level),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst)          cur_level <= '0;
    else if (accept)  cur_level <= win_lvl;
    else if (stk_pop) cur_level <= stk_top;
  end

  pvic_ack_fsm #(.N_IN(N_IN), .VEC_W(VEC_W), .TMO_LIMIT(TMO_LIMIT)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_oh   (win_onehot),
    .vec_valid  (vec_valid),
    .vec_data   (vec_data),
    .ack_vec    (ack_vec),
    .busy       (busy),
    .tmo_fire   (tmo_fire),
    .int_valid  (int_valid),
    .int_vector (int_vector),
    .int_buserr (int_buserr)
  );

  assign dev_ack = ack_vec[N_SRC-1:0];
  assign nmi_ack = ack_vec[N_SRC];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) accept |-> !stk_full); // R9
  AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (rst) accept |=> (cur_level > $past(cur_level))); // R3
  AST_READY_GATE: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(cpu_ready)); // R5
  AST_EOS_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (rst) (busy && cpu_eos && !tmo_fire) |=> $stable(cur_level)); // R9
endmodule

// File: tb/sim_pvic_top.sv
`timescale 1ns/1ps
module sim_pvic_top;
  localparam int N_SRC = 4;
  localparam int VEC_W = 4;
  localparam int TMO   = 8;
  localparam int N_IN  = N_SRC + 1;
  localparam int LVL_W = $clog2(N_SRC + 2);

  logic             clk = 1'b0;
  logic             rst;
  logic [N_SRC-1:0] irq_req;
  logic             nmi_req;
  logic             cpu_ready;
  logic             cpu_eos;
  logic             vec_valid;
  logic [VEC_W-1:0] vec_data;
  logic [N_SRC-1:0] dev_ack;
  logic             nmi_ack;
  logic             int_valid;
  logic [VEC_W-1:0] int_vector;
  logic             int_buserr;
  logic [LVL_W-1:0] cur_level;
  logic [N_IN-1:0]  ack_all;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign ack_all = {nmi_ack, dev_ack};

  pvic_top #(.N_SRC(N_SRC), .VEC_W(VEC_W), .TMO_LIMIT(TMO)) u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req),
    .cpu_ready(cpu_ready), .cpu_eos(cpu_eos), .vec_valid(vec_valid),
    .vec_data(vec_data), .dev_ack(dev_ack), .nmi_ack(nmi_ack),
    .int_valid(int_valid), .int_vector(int_vector),
    .int_buserr(int_buserr), .cur_level(cur_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // waits up to max_cyc edges for any acknowledge; idx = -1 if none
  task automatic wait_ack(input int max_cyc, output int idx, output int lat);
    idx = -1;
    lat = 0;
    for (int k = 1; k <= max_cyc; k++) begin
      @(posedge clk);
      #1;
      if (ack_all != '0) begin
        lat = k;
        for (int b = 0; b < N_IN; b++) if (ack_all[b]) idx = b;
        break;
      end
    end
  endtask

  // device answers with vector v so that vec_valid is sampled d edges after ack rose
  task automatic capture(input int d, input logic [VEC_W-1:0] v);
    step(d - 1);
    chk(ack_all != '0, "R6 ack held before vector", int'(ack_all), 1);
    vec_valid = 1'b1;
    vec_data  = v;
    step(1);
    vec_valid = 1'b0;
    chk(int_valid == 1'b1, "R7 int_valid after vector", int'(int_valid), 1);
    chk(int_vector == v, "R7 int_vector value", int'(int_vector), int'(v));
    chk(ack_all == '0, "R6 ack dropped after vector", int'(ack_all), 0);
    chk(int_buserr == 1'b0, "R8 no buserr on capture", int'(int_buserr), 0);
    step(1);
    chk(int_valid == 1'b0, "R7 int_valid one cycle", int'(int_valid), 0);
  endtask

  task automatic eos(input int exp_lvl);
    cpu_eos = 1'b1;
    step(1);
    cpu_eos = 1'b0;
    chk(int'(cur_level) == exp_lvl, "R9 level after eos", int'(cur_level), exp_lvl);
  endtask

  // raise one maskable source from idle, expect grant at latency 3, capture
  task automatic serve_src(input int src, input logic [VEC_W-1:0] v);
    int idx, lat;
    irq_req = N_SRC'(1) << src;
    wait_ack(6, idx, lat);
    chk(idx == src, "R2 grant to raised source", idx, src);
    chk(lat == 3, "R5 maskable grant latency", lat, 3);
    chk(int'(cur_level) == src + 1, "R9 level on grant", int'(cur_level), src + 1);
    irq_req = '0;
    capture(1, v);
  endtask

  function automatic int highest(input int m);
    int h = -1;
    for (int b = 0; b < N_SRC; b++) if (m[b]) h = b;
    return h;
  endfunction

  initial begin
    #750000;
    chk(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int idx, lat;
    rst = 1'b1; irq_req = '0; nmi_req = 1'b0; cpu_ready = 1'b1;
    cpu_eos = 1'b0; vec_valid = 1'b0; vec_data = '0;
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(ack_all == '0, "R1 acks after reset", int'(ack_all), 0);
    chk(int_valid == 1'b0, "R1 int_valid after reset", int'(int_valid), 0);
    chk(int_buserr == 1'b0, "R1 int_buserr after reset", int'(int_buserr), 0);
    chk(cur_level == '0, "R1 level after reset", int'(cur_level), 0);

    // R9 eos with nothing saved
    eos(0);

    // R2/R5/R7: every request mask, vector delays 1..TMO
    for (int m = 1; m < (1 << N_SRC); m++) begin
      int h;
      h = highest(m);
      irq_req = N_SRC'(m);
      wait_ack(6, idx, lat);
      chk(idx == h, "R2 highest level wins", idx, h);
      chk(lat == 3, "R5 grant latency", lat, 3);
      chk(int'(cur_level) == h + 1, "R9 level equals granted", int'(cur_level), h + 1);
      irq_req = '0;
      capture((m % TMO) + 1, VEC_W'(m * 7 + 3));
      eos(0);
      step(2);
    end

    // R3: strict-greater masking against every base level
    for (int base = 1; base <= N_SRC; base++) begin
      serve_src(base - 1, VEC_W'(base));
      step(2);
      for (int i = 0; i < N_SRC; i++) begin
        irq_req = N_SRC'(1) << i;
        wait_ack(6, idx, lat);
        if (i + 1 > base) begin
          chk(idx == i, "R3 higher level preempts", idx, i);
          chk(lat == 3, "R5 preempt latency", lat, 3);
          irq_req = '0;
          capture(2, VEC_W'(i + 8));
          eos(base);
        end else begin
          chk(idx == -1, "R3 not-higher request ignored", idx, -1);
          chk(int'(cur_level) == base, "R3 level kept", int'(cur_level), base);
          irq_req = '0;
        end
        step(3);
      end
      eos(0);
      step(2);
    end

    // R3: held lower request taken right after service ends
    serve_src(2, 4'h5);
    irq_req = 4'b0001;
    wait_ack(6, idx, lat);
    chk(idx == -1, "R3 lower request waits", idx, -1);
    eos(0);
    step(1);
    chk(dev_ack == 4'b0001, "R3 pending request granted after eos", int'(dev_ack), 1);
    irq_req = '0;
    capture(1, 4'h6);
    eos(0);
    step(3);

    // R5: processor not ready holds acceptance
    cpu_ready = 1'b0;
    irq_req = 4'b0010;
    wait_ack(6, idx, lat);
    chk(idx == -1, "R5 no grant while not ready", idx, -1);
    cpu_ready = 1'b1;
    step(1);
    chk(dev_ack == 4'b0010, "R5 grant once ready", int'(dev_ack), 2);
    irq_req = '0;
    capture(3, 4'h9);
    eos(0);
    step(3);

    // R5: eos cycle blocks acceptance
    irq_req = 4'b0100;
    cpu_eos = 1'b1;
    step(3);
    chk(ack_all == '0, "R5 no grant during eos", int'(ack_all), 0);
    cpu_eos = 1'b0;
    step(1);
    chk(dev_ack == 4'b0100, "R5 grant after eos released", int'(dev_ack), 4);
    irq_req = '0;
    capture(1, 4'h1);
    eos(0);
    step(3);

    // R4: non-maskable over the highest maskable level
    serve_src(3, 4'h2);
    nmi_req = 1'b1;
    wait_ack(8, idx, lat);
    chk(idx == N_SRC, "R4 nmi granted over top level", idx, N_SRC);
    chk(lat == 4, "R5 nmi grant latency", lat, 4);
    chk(int'(cur_level) == N_SRC + 1, "R4 nmi level", int'(cur_level), N_SRC + 1);
    capture(2, 4'hF);
    nmi_req = 1'b0;
    step(3);
    nmi_req = 1'b1;
    wait_ack(8, idx, lat);
    chk(idx == -1, "R4 nmi waits during nmi service", idx, -1);
    chk(int'(cur_level) == N_SRC + 1, "R4 level during wait", int'(cur_level), N_SRC + 1);
    eos(N_SRC);
    step(1);
    chk(nmi_ack == 1'b1, "R4 remembered nmi edge granted", int'(nmi_ack), 1);
    capture(1, 4'hE);
    eos(N_SRC);
    wait_ack(8, idx, lat);
    chk(idx == -1, "R4 held nmi level does not retrigger", idx, -1);
    nmi_req = 1'b0;
    eos(0);
    step(3);

    // R6/R8: timeout from foreground
    irq_req = 4'b0001;
    wait_ack(6, idx, lat);
    chk(idx == 0, "R6 grant before timeout", idx, 0);
    irq_req = '0;
    step(TMO - 1);
    chk(dev_ack == 4'b0001, "R6 ack held until last window cycle", int'(dev_ack), 1);
    step(1);
    chk(int_buserr == 1'b1, "R8 buserr at timeout", int'(int_buserr), 1);
    chk(int_valid == 1'b0, "R8 no int_valid at timeout", int'(int_valid), 0);
    chk(ack_all == '0, "R6 ack dropped at timeout", int'(ack_all), 0);
    chk(cur_level == '0, "R8 level restored to 0", int'(cur_level), 0);
    step(1);
    chk(int_buserr == 1'b0, "R8 buserr one cycle", int'(int_buserr), 0);
    eos(0);
    step(3);

    // R8: timeout while nested restores the interrupted level
    serve_src(1, 4'h3);
    irq_req = 4'b1000;
    wait_ack(6, idx, lat);
    chk(idx == 3, "R8 nested grant", idx, 3);
    irq_req = '0;
    step(TMO);
    chk(int_buserr == 1'b1, "R8 nested buserr", int'(int_buserr), 1);
    chk(int'(cur_level) == 2, "R8 nested level restored", int'(cur_level), 2);
    step(1);
    eos(0);
    step(3);

    // R9: eos during handshake has no effect
    irq_req = 4'b0010;
    wait_ack(6, idx, lat);
    irq_req = '0;
    cpu_eos = 1'b1;
    step(1);
    cpu_eos = 1'b0;
    chk(int'(cur_level) == 2, "R9 eos ignored in handshake", int'(cur_level), 2);
    capture(2, 4'h4);
    eos(0);
    step(2);

    report();
    $finish;
  end
endmodule